// File: doc/BRIEF.md
# Hiccup Fault Protection Sequencer

This block is the protection state machine of a synchronous buck regulator controller. It works in PWM cycles: on each system clock where `cyc_valid` is high, it samples one PWM cycle's worth of comparator results. These are an overcurrent detect taken while the high-side switch conducts, an undervoltage and an overvoltage flag on the feedback node, two thermal comparator flags, and the soft-start done flag. From these it decides whether the power stage switches normally, has its high-side pulse cut short, holds the low-side switch on, or goes to high impedance.

Each fault has its own counter of consecutive cycles. Any cycle without that fault clears its counter. Sustained overcurrent or undervoltage starts a hiccup retry. The soft-start is restarted three times as dummy cycles with the drivers off, and the fourth restart is a real ramp. Sustained overvoltage first holds the low-side switch on and then latches the drivers off until the output has collapsed. Over-temperature stops switching until a separate cool-down comparator reports that the die has cooled, which gives thermal hysteresis.

The soft-start ramp generator consumes `ss_restart` and reports `ss_done`. The PWM generator consumes `pulse_term`, `force_low` and `drv_off`. `status` and `dummy_num` expose the sequencer state.

Top module: `hiccup_seq`

## Requirements
- R1: After reset, `status` is 1 (ramping) and `ss_restart`, `drv_off`, `dummy_cyc`, `dummy_num` are all 0. The status codes are: 0 normal, 1 ramping, 2 dummy soft-start, 3 overvoltage latched, 4 thermal stop.
- R2: `pulse_term` follows `oc_det` in the same clock, with no register in between, while `status` is 0 or 1. It is 0 in every other state.
- R3: In state 0, 8 consecutive valid cycles with `oc_det` move the sequencer to state 2 with `dummy_num` = 1 and a one-clock `ss_restart` pulse. A valid cycle without `oc_det` restarts the count, so runs of 1 to 7 leave state 0.
- R4: In state 1 the overcurrent count is held at zero, so no run of overcurrent cycles causes a hiccup. After the ramp ends, the count starts fresh.
- R5: Clocks with `cyc_valid` low change no state and no counter, whatever the flags are.
- R6: In state 2, each valid cycle with `ss_done` emits an `ss_restart` pulse and advances `dummy_num` (1, 2, 3). The one after dummy 3 enters state 1 with drivers enabled. In state 2, `drv_off` and `dummy_cyc` are 1.
- R7: In state 1, a valid cycle with `ss_done` moves to state 0 unless an overvoltage trip takes priority.
- R8: In state 0, 8 consecutive valid cycles with `uv_flag` start the same hiccup as R3. Runs of 1 to 7 do not. Undervoltage is ignored in state 1.
- R9: `force_low` follows `ov_flag` in the same clock while `status` is 0 or 1, and is 0 otherwise.
- R10: In state 0 or 1, 32 consecutive valid cycles with `ov_flag` move to state 3 with `drv_off` = 1. Runs of 1 to 31 do not.
- R11: In state 3, 8 consecutive valid cycles with `uv_flag` start the hiccup of R3. Shorter runs leave state 3.
- R12: A valid cycle with `ot_hot` enters state 4 from any state, ahead of every other transition. State 4 holds, with drivers off, until a valid cycle with `ot_cool`. That cycle enters state 1 with an `ss_restart` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Marks the clock on which one PWM cycle's flags are sampled |
| oc_det | input | 1 | Overcurrent seen while the high-side switch is on |
| uv_flag | input | 1 | Feedback below the undervoltage threshold |
| ov_flag | input | 1 | Feedback above the overvoltage threshold |
| ot_hot | input | 1 | Die above the upper thermal threshold |
| ot_cool | input | 1 | Die below the lower thermal threshold |
| ss_done | input | 1 | Soft-start ramp has finished |
| pulse_term | output | 1 | End the current high-side pulse now |
| force_low | output | 1 | Hold the low-side switch on |
| drv_off | output | 1 | Put both gate drivers in high impedance |
| ss_restart | output | 1 | One-clock request to discharge and restart soft-start |
| dummy_cyc | output | 1 | A dummy soft-start cycle is in progress |
| dummy_num | output | 2 | Dummy cycle number 1..3, 0 outside dummy cycles |
| status | output | 3 | Sequencer state code (see R1) |

## Verification
The bench builds the block with its default limits: 8 cycles for overcurrent and undervoltage, 32 for overvoltage, and 3 dummy cycles. These values are small enough that every run length from one cycle up to the trip length can be swept, each broken by a clean cycle. This shows both the exact trip cycle and the clearing of each counter. The same configuration lets the full retry path be walked within a few hundred cycles. That path covers the overvoltage latch, its undervoltage exit, the three dummy restarts and the ramp, and thermal entry from the normal, latched and hiccup-adjacent states.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_NORM    = 3'd0,
        ST_RAMP    = 3'd1,
        ST_DUMMY   = 3'd2,
        ST_OVLATCH = 3'd3,
        ST_THERM   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/hic_run_counter.sv
module hic_run_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fault,
    input  logic hold,
    output logic trip
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Trip on the LIMIT-th consecutive faulty cycle.
    assign trip = tick && fault && !hold && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = '0;
        end else if (tick) begin
            if (!fault || trip) cnt_d = '0;
            else                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
    parameter int unsigned OC_LIMIT     = 8,
    parameter int unsigned UV_LIMIT     = 8,
    parameter int unsigned OV_LIMIT     = 32,
    parameter int unsigned DUMMY_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_valid,
    input  logic       oc_det,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       ot_hot,
    input  logic       ot_cool,
    input  logic       ss_done,
    output logic       pulse_term,
    output logic       force_low,
    output logic       drv_off,
    output logic       ss_restart,
    output logic       dummy_cyc,
    output logic [1:0] dummy_num,
    output logic [2:0] status
);
    import hiccup_pkg::*;

    localparam int unsigned DW = $clog2(DUMMY_CYCLES + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [DW-1:0] dnum;
        logic          restart;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic switching;
    logic oc_trip, uv_trip, ov_trip;

    assign switching = (r_q.st == ST_NORM) || (r_q.st == ST_RAMP);

    // Per-fault consecutive-cycle counters; each is held cleared outside
    // the states where its fault is watched.
    hic_run_counter #(.LIMIT(OC_LIMIT)) u_oc_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_valid),
        .fault (oc_det),
        .hold  (r_q.st != ST_NORM),
        .trip  (oc_trip)
    );

    hic_run_counter #(.LIMIT(UV_LIMIT)) u_uv_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_valid),
        .fault (uv_flag),
        .hold  (!((r_q.st == ST_NORM) || (r_q.st == ST_OVLATCH))),
        .trip  (uv_trip)
    );

    hic_run_counter #(.LIMIT(OV_LIMIT)) u_ov_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_valid),
        .fault (ov_flag),
        .hold  (!switching),
        .trip  (ov_trip)
    );

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (cyc_valid) begin
            if (ot_hot && (r_q.st != ST_THERM)) begin
                r_d.st   = ST_THERM;
                r_d.dnum = '0;
            end else begin
                unique case (r_q.st)
                    ST_NORM: begin
                        if (ov_trip) begin
                            r_d.st = ST_OVLATCH;
                        end else if (oc_trip || uv_trip) begin
                            r_d.st      = ST_DUMMY;
                            r_d.dnum    = DW'(1);
                            r_d.restart = 1'b1;
                        end
                    end
                    ST_RAMP: begin
                        if (ov_trip)      r_d.st = ST_OVLATCH;
                        else if (ss_done) r_d.st = ST_NORM;
                    end
                    ST_DUMMY: begin
                        if (ss_done) begin
                            r_d.restart = 1'b1;
                            if (r_q.dnum == DW'(DUMMY_CYCLES)) begin
                                r_d.st   = ST_RAMP;
                                r_d.dnum = '0;
                            end else begin
                                r_d.dnum = r_q.dnum + 1'b1;
                            end
                        end
                    end
                    ST_OVLATCH: begin
                        if (uv_trip) begin
                            r_d.st      = ST_DUMMY;
                            r_d.dnum    = DW'(1);
                            r_d.restart = 1'b1;
                        end
                    end
                    ST_THERM: begin
                        if (ot_cool) begin
                            r_d.st      = ST_RAMP;
                            r_d.restart = 1'b1;
                        end
                    end
                    default: r_d.st = ST_RAMP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_RAMP;
            r_q.dnum    <= '0;
            r_q.restart <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_term = oc_det  && switching;
    assign force_low  = ov_flag && switching;
    assign drv_off    = (r_q.st == ST_DUMMY) || (r_q.st == ST_OVLATCH) ||
                        (r_q.st == ST_THERM);
    assign ss_restart = r_q.restart;
    assign dummy_cyc  = (r_q.st == ST_DUMMY);
    assign dummy_num  = 2'(r_q.dnum);
    assign status     = r_q.st;
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk #(
    parameter int unsigned DUMMY_CYCLES = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_valid,
    input logic       oc_det,
    input logic       ot_hot,
    input logic       ot_cool,
    input logic       pulse_term,
    input logic       ss_restart,
    input logic       dummy_cyc,
    input logic [1:0] dummy_num,
    input logic [2:0] status
);
    p_term_needs_oc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_term |-> oc_det);

    p_ramp_no_hiccup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd1 && cyc_valid && !ot_hot) |=> (status != 3'd2));

    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> ($stable(status) && !ss_restart));

    p_restart_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |-> (status == 3'd2 || status == 3'd1));

    p_dummy_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_cyc |-> (dummy_num != 2'd0 && 32'(dummy_num) <= DUMMY_CYCLES));

    p_ovlatch_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3) |=> (status == 3'd3 || status == 3'd2 || status == 3'd4));

    p_hot_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && ot_hot && !ot_cool) |=> (status == 3'd4));

    p_therm_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd4 && !(cyc_valid && ot_cool)) |=> (status == 3'd4));
endmodule

bind hiccup_seq hiccup_seq_chk #(.DUMMY_CYCLES(DUMMY_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_valid  (cyc_valid),
    .oc_det     (oc_det),
    .ot_hot     (ot_hot),
    .ot_cool    (ot_cool),
    .pulse_term (pulse_term),
    .ss_restart (ss_restart),
    .dummy_cyc  (dummy_cyc),
    .dummy_num  (dummy_num),
    .status     (status)
);

// File: tb/hiccup_seq_test.sv
module hiccup_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_valid = 1'b0, oc_det = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
    logic ot_hot = 1'b0, ot_cool = 1'b0, ss_done = 1'b0;
    logic pulse_term, force_low, drv_off, ss_restart, dummy_cyc;
    logic [1:0] dummy_num;
    logic [2:0] status;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic pt_s, fl_s;

    localparam int S_NORM = 0, S_RAMP = 1, S_DUMMY = 2, S_OVL = 3, S_THERM = 4;

    always #2.5 clk = ~clk;

    hiccup_seq uut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .oc_det(oc_det),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_hot(ot_hot), .ot_cool(ot_cool),
        .ss_done(ss_done), .pulse_term(pulse_term), .force_low(force_low),
        .drv_off(drv_off), .ss_restart(ss_restart), .dummy_cyc(dummy_cyc),
        .dummy_num(dummy_num), .status(status)
    );

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, capture the same-clock outputs,
    // then return just after the rising edge with registers settled.
    task automatic step(input logic v, input logic oc, input logic uv,
                        input logic ov, input logic hot, input logic cool,
                        input logic ssd);
        @(negedge clk);
        cyc_valid = v; oc_det = oc; uv_flag = uv; ov_flag = ov;
        ot_hot = hot; ot_cool = cool; ss_done = ssd;
        #1;
        pt_s = pulse_term;
        fl_s = force_low;
        @(posedge clk);
        #1;
    endtask

    task automatic clean();
        step(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic to_ramp_from_dummy();
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(status, S_RAMP, "R1 reset status");
        chk(ss_restart, 0, "R1 reset restart");
        chk(drv_off, 0, "R1 reset drv_off");
        chk(dummy_cyc, 0, "R1 reset dummy_cyc");
        chk(dummy_num, 0, "R1 reset dummy_num");

        step(1, 0, 0, 0, 0, 0, 1);
        chk(status, S_NORM, "R7 ramp done");

        // R3: overcurrent run-length sweep
        for (int n = 1; n <= 8; n++) begin
            for (int k = 0; k < n; k++) begin
                step(1, 1, 0, 0, 0, 0, 0);
                chk(pt_s, 1, "R2 pulse_term in normal");
            end
            if (n < 8) begin
                chk(status, S_NORM, "R3 short oc run");
                clean();
            end else begin
                chk(status, S_DUMMY, "R3 oc hiccup");
                chk(dummy_num, 1, "R3 dummy_num");
                chk(ss_restart, 1, "R3 restart pulse");
                chk(drv_off, 1, "R6 drv_off in dummy");
            end
        end

        // R6: dummy sequence
        step(1, 1, 0, 0, 0, 0, 0);
        chk(pt_s, 0, "R2 pulse_term masked in dummy");
        chk(ss_restart, 0, "R6 restart one clock");
        chk(dummy_cyc, 1, "R6 dummy_cyc");
        step(1, 0, 0, 0, 0, 0, 1);
        chk(dummy_num, 2, "R6 dummy 2");
        chk(ss_restart, 1, "R6 restart 2");
        step(1, 0, 0, 0, 0, 0, 1);
        chk(dummy_num, 3, "R6 dummy 3");
        clean();
        chk(status, S_DUMMY, "R6 dummy waits");
        chk(dummy_num, 3, "R6 dummy 3 held");
        step(1, 0, 0, 0, 0, 0, 1);
        chk(status, S_RAMP, "R6 real ramp");
        chk(ss_restart, 1, "R6 ramp restart");
        chk(drv_off, 0, "R6 drivers on in ramp");
        chk(dummy_num, 0, "R6 dummy_num cleared");

        // R4 / R8: counters held during ramp
        for (int k = 0; k < 20; k++) step(1, 1, 0, 0, 0, 0, 0);
        chk(status, S_RAMP, "R4 oc held in ramp");
        chk(pt_s, 1, "R2 pulse_term in ramp");
        for (int k = 0; k < 10; k++) step(1, 0, 1, 0, 0, 0, 0);
        chk(status, S_RAMP, "R8 uv ignored in ramp");
        step(1, 0, 0, 0, 0, 0, 1);
        chk(status, S_NORM, "R7 normal again");
        for (int k = 0; k < 7; k++) step(1, 1, 0, 0, 0, 0, 0);
        chk(status, S_NORM, "R4 fresh count after ramp");
        clean();

        // R5: invalid clocks neither count nor clear
        for (int k = 0; k < 5; k++) step(1, 1, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 1, 1, 1);
        chk(status, S_NORM, "R5 idle clocks ignored");
        chk(ss_restart, 0, "R5 no restart when idle");
        for (int k = 0; k < 2; k++) step(1, 1, 0, 0, 0, 0, 0);
        chk(status, S_NORM, "R5 count kept at 7");
        step(1, 1, 0, 0, 0, 0, 0);
        chk(status, S_DUMMY, "R5 trip at 8 across gap");
        to_ramp_from_dummy();
        step(1, 0, 0, 0, 0, 0, 1);

        // R8: undervoltage sweep
        for (int n = 1; n <= 8; n++) begin
            for (int k = 0; k < n; k++) step(1, 0, 1, 0, 0, 0, 0);
            if (n < 8) begin
                chk(status, S_NORM, "R8 short uv run");
                clean();
            end else begin
                chk(status, S_DUMMY, "R8 uv hiccup");
                chk(ss_restart, 1, "R8 restart pulse");
            end
        end
        to_ramp_from_dummy();
        step(1, 0, 0, 0, 0, 0, 1);

        // R9 / R10: overvoltage sweep
        for (int n = 1; n <= 32; n++) begin
            for (int k = 0; k < n; k++) begin
                step(1, 0, 0, 1, 0, 0, 0);
                if (k == 0) chk(fl_s, 1, "R9 force_low");
            end
            if (n < 32) begin
                chk(status, S_NORM, "R10 short ov run");
                clean();
            end else begin
                chk(status, S_OVL, "R10 ov latch");
                chk(drv_off, 1, "R10 drivers off");
            end
        end
        step(1, 0, 0, 1, 0, 0, 0);
        chk(fl_s, 0, "R9 force_low off when latched");

        // R11: exit from overvoltage latch
        for (int k = 0; k < 7; k++) step(1, 0, 1, 0, 0, 0, 0);
        clean();
        chk(status, S_OVL, "R11 short uv run in latch");
        for (int k = 0; k < 8; k++) step(1, 0, 1, 0, 0, 0, 0);
        chk(status, S_DUMMY, "R11 latch to hiccup");
        chk(dummy_num, 1, "R11 dummy 1");
        to_ramp_from_dummy();
        chk(status, S_RAMP, "R6 back in ramp");
        for (int k = 0; k < 32; k++) step(1, 0, 0, 1, 0, 0, 0);
        chk(status, S_OVL, "R10 ov latch from ramp");

        // R12: thermal stop with hysteresis
        step(1, 0, 0, 0, 1, 0, 0);
        chk(status, S_THERM, "R12 hot from latch");
        chk(drv_off, 1, "R12 drivers off");
        for (int k = 0; k < 5; k++) step(1, 1, 0, 1, 0, 0, 1);
        chk(status, S_THERM, "R12 holds until cool");
        chk(pt_s, 0, "R2 pulse_term masked in thermal");
        chk(fl_s, 0, "R9 force_low masked in thermal");
        step(1, 0, 0, 0, 0, 1, 0);
        chk(status, S_RAMP, "R12 cool resumes");
        chk(ss_restart, 1, "R12 restart on resume");
        step(1, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < 7; k++) step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 1, 0, 0);
        chk(status, S_THERM, "R12 hot beats oc trip");
        chk(ss_restart, 0, "R12 no restart on hot");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule